// File: doc/BRIEF.md
# Hashed Page Table Walker

The walker resolves a virtual page through a page table kept in main memory once faster translation paths have missed. A walk is launched with a one-cycle start pulse carrying the segment's 24-bit virtual segment identifier, the 32-bit effective address and the 32-bit table base/mask register. The walker hashes these values into the address of a 64-byte group of eight 8-byte entries. It reads the entries one at a time over a request/acknowledge memory port and compares each against the page being looked up.

If no entry in the first group matches, the walker complements the hash and searches a second group. The walk ends with a one-cycle done pulse. On a hit it returns the real address and the entry's storage-control and protection fields. If both groups miss, it raises a fault instead. Only one walk runs at a time.

All bit indices below are numbered with 0 as the least significant bit.

Top module: `hpt_walker`

## Requirements
- R1: The first pass reads the group at {sdr_i[31:25], (n[18:10] & sdr_i[8:0]) | sdr_i[24:16], n[9:0], 6'b0}, where n = vsid_i[18:0] ^ {3'b000, ea_i[27:12]}.
- R2: When all eight entries of the first group miss, a second pass reads the group given by the R1 formula with n replaced by ~n.
- R3: Within a pass, entry k (k = 0 to 7) is read at group address + 8*k, in increasing k. The walk stops at the first entry that matches, so the number of reads is 8*pass + k + 1.
- R4: Word 0 of an entry sits in data bits 63:32: V at bit 63, VSID at bits 62:39, H at bit 38 and API at bits 37:32. An entry matches only if V=1, H equals the pass number (0 for the first pass, 1 for the second), its VSID equals vsid_i and its API equals ea_i[27:22].
- R5: Word 1 of an entry sits in data bits 31:0: RPN at bits 31:12, WIMG at bits 6:3 and PP at bits 1:0. On a hit, ra_o = {RPN, ea_i[11:0]}, wimg_o = WIMG and pp_o = PP.
- R6: After 16 misses the walk ends with fault_o=1 and hit_o=0. done_o is high for exactly one cycle, in the cycle after the acknowledge of the final read, and exactly one of hit_o and fault_o is high while done_o is high.
- R7: A start pulse that arrives while busy_o is high is ignored, including a pulse in the cycle of the final acknowledge. A start pulse in the cycle done_o is high is accepted.
- R8: During reset, busy_o, mem_req_o and done_o are low.
- R9: mem_req_o stays high with a stable mem_addr_o until mem_ack_i is seen. mem_data_i is taken in the acknowledge cycle, and each acknowledge consumes exactly one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse for a walk |
| vsid_i | input | 24 | Virtual segment identifier |
| ea_i | input | 32 | Effective address |
| sdr_i | input | 32 | Table origin (31:16) and hash mask (8:0) |
| busy_o | output | 1 | A walk is in progress |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_ack_i | input | 1 | Memory read acknowledge; data valid |
| mem_data_i | input | 64 | Entry read from memory |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| hit_o | output | 1 | Walk found a matching entry |
| fault_o | output | 1 | Walk missed in both groups |
| ra_o | output | 32 | Real address on a hit |
| wimg_o | output | 4 | Storage-control bits of the hit entry |
| pp_o | output | 2 | Protection bits of the hit entry |

## Verification
The final memory acknowledge of a walk and a fresh start pulse can land in the same cycle. At that edge the walker is still busy, so the pulse must be dropped. One cycle later, in the done cycle, a pulse must be taken. The memory model raises start exactly alongside the last acknowledge, using different operands, and the bench then confirms that no further read appears. A second test pulses start in the done cycle and checks that busy_o rises and that the new walk returns the correct result. Near-miss entries that differ from a real match in a single field fill the slots ahead of each target, and entries after the target would return a wrong address if the walk failed to stop.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned VSID_W  = 24;
  localparam int unsigned HASH_W  = 19;
  localparam int unsigned MASK_W  = 9;
  localparam int unsigned RPN_W   = 20;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned API_W   = 6;
  localparam int unsigned WIMG_W  = 4;
  localparam int unsigned PP_W    = 2;
  localparam int unsigned SLOTS   = 8;
  localparam int unsigned SLOT_W  = $clog2(SLOTS);
  localparam int unsigned ENT_B   = 3;
  localparam int unsigned GRP_LSB = SLOT_W + ENT_B;

  typedef struct packed {
    logic              v;
    logic [VSID_W-1:0] vsid;
    logic              h;
    logic [API_W-1:0]  api;
    logic [RPN_W-1:0]  rpn;
    logic [2:0]        rsv_a;
    logic              r;
    logic              c;
    logic [WIMG_W-1:0] wimg;
    logic              rsv_b;
    logic [PP_W-1:0]   pp;
  } pte_t;
endpackage

// File: rtl/ptw_hash.sv
module ptw_hash
  import ptw_pkg::*;
(
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [ADDR_W-1:0] sdr_i,
  input  logic              sec_i,
  output logic [ADDR_W-1:0] grp_o
);
  localparam int unsigned LO_W = HASH_W - MASK_W;

  logic [HASH_W-1:0] pri_hash;
  logic [HASH_W-1:0] hash;
  logic [MASK_W-1:0] mid;

  assign pri_hash = vsid_i[HASH_W-1:0] ^ {3'b000, ea_i[27:12]};
  assign hash     = sec_i ? ~pri_hash : pri_hash;
  // masked upper hash merged into the table origin
  assign mid      = (hash[HASH_W-1:LO_W] & sdr_i[MASK_W-1:0]) | sdr_i[24:16];
  assign grp_o    = {sdr_i[31:25], mid, hash[LO_W-1:0], {GRP_LSB{1'b0}}};

  logic unused_bits;
  assign unused_bits = ^{vsid_i[VSID_W-1:HASH_W], ea_i[31:28], ea_i[11:0], sdr_i[15:9]};
endmodule

// File: rtl/ptw_match.sv
module ptw_match
  import ptw_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [API_W-1:0]  api_i,
  input  logic              sec_i,
  output logic              hit_o,
  output logic [RPN_W-1:0]  rpn_o,
  output logic [WIMG_W-1:0] wimg_o,
  output logic [PP_W-1:0]   pp_o
);
  pte_t ent;
  assign ent    = pte_t'(data_i);

  assign hit_o  = ent.v & (ent.h == sec_i) & (ent.vsid == vsid_i) & (ent.api == api_i);
  assign rpn_o  = ent.rpn;
  assign wimg_o = ent.wimg;
  assign pp_o   = ent.pp;

  logic unused_fields;
  assign unused_fields = ^{ent.rsv_a, ent.r, ent.c, ent.rsv_b};
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mem_ack_i,
  input  logic              ent_hit_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              sec_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              fin_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic              busy_q;
  logic              sec_q;
  logic [SLOT_W-1:0] slot_q;
  logic              last_slot;

  assign last_slot = (slot_q == LAST);
  assign accept_o  = start_i & ~busy_q;
  assign fin_o     = busy_q & mem_ack_i & (ent_hit_i | (last_slot & sec_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sec_q  <= 1'b0;
      slot_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      sec_q  <= 1'b0;
      slot_q <= '0;
    end else if (busy_q && mem_ack_i) begin
      if (fin_o) begin
        busy_q <= 1'b0;
      end else if (last_slot) begin
        sec_q  <= 1'b1;   // retry with complemented hash
        slot_q <= '0;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign sec_o  = sec_q;
  assign slot_o = slot_q;

  p_ignore_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i && !mem_ack_i |=> busy_q && $stable(slot_q) && $stable(sec_q));

  p_retry_after_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_q) |-> $past(slot_q) == LAST && slot_q == '0 && busy_q);

  p_slot_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !mem_ack_i |=> $stable(slot_q) && $stable(sec_q));
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import ptw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [ADDR_W-1:0] sdr_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              done_o,
  output logic              hit_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] ra_o,
  output logic [WIMG_W-1:0] wimg_o,
  output logic [PP_W-1:0]   pp_o
);
  logic              accept, busy, sec, fin, ent_hit;
  logic [SLOT_W-1:0] slot;
  logic [VSID_W-1:0] vsid_q;
  logic [ADDR_W-1:0] ea_q, sdr_q, grp;
  logic [RPN_W-1:0]  ent_rpn;
  logic [WIMG_W-1:0] ent_wimg;
  logic [PP_W-1:0]   ent_pp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vsid_q <= '0;
      ea_q   <= '0;
      sdr_q  <= '0;
    end else if (accept) begin
      vsid_q <= vsid_i;
      ea_q   <= ea_i;
      sdr_q  <= sdr_i;
    end
  end

  ptw_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mem_ack_i (mem_ack_i),
    .ent_hit_i (ent_hit),
    .accept_o  (accept),
    .busy_o    (busy),
    .sec_o     (sec),
    .slot_o    (slot),
    .fin_o     (fin)
  );

  ptw_hash u_hash (
    .vsid_i (vsid_q),
    .ea_i   (ea_q),
    .sdr_i  (sdr_q),
    .sec_i  (sec),
    .grp_o  (grp)
  );

  ptw_match u_match (
    .data_i (mem_data_i),
    .vsid_i (vsid_q),
    .api_i  (ea_q[27:22]),
    .sec_i  (sec),
    .hit_o  (ent_hit),
    .rpn_o  (ent_rpn),
    .wimg_o (ent_wimg),
    .pp_o   (ent_pp)
  );

  assign mem_req_o  = busy;
  assign mem_addr_o = {grp[ADDR_W-1:GRP_LSB], slot, {ENT_B{1'b0}}};
  assign busy_o     = busy;

  logic              done_q, hit_q, fault_q;
  logic [ADDR_W-1:0] ra_q;
  logic [WIMG_W-1:0] wimg_q;
  logic [PP_W-1:0]   pp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      fault_q <= 1'b0;
      ra_q    <= '0;
      wimg_q  <= '0;
      pp_q    <= '0;
    end else begin
      done_q <= fin;
      if (fin) begin
        hit_q   <= ent_hit;
        fault_q <= ~ent_hit;
        ra_q    <= ent_hit ? {ent_rpn, ea_q[OFF_W-1:0]} : '0;
        wimg_q  <= ent_hit ? ent_wimg : '0;
        pp_q    <= ent_hit ? ent_pp : '0;
      end
    end
  end

  assign done_o  = done_q;
  assign hit_o   = hit_q;
  assign fault_o = fault_q;
  assign ra_o    = ra_q;
  assign wimg_o  = wimg_q;
  assign pp_o    = pp_q;

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_kind_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot({hit_o, fault_o}));

  p_done_after_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_ack_i && mem_req_o));

  p_ra_offset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && hit_o |-> ra_o[OFF_W-1:0] == ea_q[OFF_W-1:0]);
endmodule

// File: tb/hpt_walker_tb.sv
`timescale 1ns/1ps
module hpt_walker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_a = 1'b0;
  logic        start_b = 1'b0;
  logic        start_i;
  logic [23:0] vsid_i = '0;
  logic [31:0] ea_i = '0;
  logic [31:0] sdr_i = '0;
  logic        busy_o, mem_req_o, mem_ack_i, done_o, hit_o, fault_o;
  logic [31:0] mem_addr_o, ra_o;
  logic [63:0] mem_data_i;
  logic [3:0]  wimg_o;
  logic [1:0]  pp_o;

  assign start_i = start_a | start_b;

  always #2 clk_i = ~clk_i;

  hpt_walker u_dut (
    .clk_i, .rst_ni, .start_i, .vsid_i, .ea_i, .sdr_i, .busy_o,
    .mem_req_o, .mem_addr_o, .mem_ack_i, .mem_data_i,
    .done_o, .hit_o, .fault_o, .ra_o, .wimg_o, .pp_o
  );

  typedef struct packed {
    logic [23:0] vsid;
    logic [31:0] ea;
    logic [31:0] sdr;
    logic [1:0]  where;  // 0 first pass, 1 second pass, 2 none
    logic [2:0]  slot;
    logic [19:0] rpn;
    logic [3:0]  wimg;
    logic [1:0]  pp;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{24'h0ABCDE, 32'h12345678, 32'h00100000, 2'd0, 3'd0, 20'hABCDE, 4'h2, 2'h2, 4'd0},
    '{24'h123456, 32'hFEDCBA98, 32'h0A000007, 2'd0, 3'd7, 20'h00F0F, 4'h9, 2'h1, 4'd1},
    '{24'hFFFFFF, 32'h00000FFF, 32'h400001FF, 2'd1, 3'd0, 20'h12345, 4'h5, 2'h3, 4'd0},
    '{24'h000001, 32'h80001000, 32'h20300003, 2'd1, 3'd5, 20'hFEDCB, 4'hC, 2'h0, 4'd2},
    '{24'h55AA55, 32'h0F0F0F0F, 32'h01000001, 2'd2, 3'd0, 20'h00000, 4'h0, 2'h0, 4'd0},
    '{24'h3C3C3C, 32'h77777000, 32'h80000000, 2'd1, 3'd7, 20'h80001, 4'hF, 2'h2, 4'd3}
  };

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [63:0] mem [logic [31:0]];
  logic [31:0] exp_addr [16];
  int  lat = 0, wait_cnt = 0, reads = 0, addr_bad = 0, stall_bad = 0;
  bit  poke_arm = 1'b0;
  int  poke_at = 0;
  logic [31:0] stall_addr = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] grp_of(logic [23:0] v, logic [31:0] ea, logic [31:0] sdr, logic sec);
    logic [18:0] n;
    n = v[18:0] ^ {3'b000, ea[27:12]};
    if (sec) n = ~n;
    return {sdr[31:25], (n[18:10] & sdr[8:0]) | sdr[24:16], n[9:0], 6'b0};
  endfunction

  function automatic logic [63:0] mk_pte(logic v, logic [23:0] vs, logic h, logic [5:0] api,
                                         logic [19:0] rpn, logic [3:0] wimg, logic [1:0] pp);
    return {v, vs, h, api, rpn, 3'b000, 1'b1, 1'b1, wimg, 1'b0, pp};
  endfunction

  // memory model: ack after lat idle cycles, one cycle wide
  always @(negedge clk_i) begin
    start_b = 1'b0;
    if (!rst_ni) begin
      mem_ack_i = 1'b0;
      wait_cnt  = 0;
    end else if (mem_ack_i) begin
      mem_ack_i = 1'b0;
    end else if (mem_req_o) begin
      if (wait_cnt == 0) stall_addr = mem_addr_o;
      else if (mem_addr_o != stall_addr) stall_bad++;
      if (wait_cnt >= lat) begin
        wait_cnt   = 0;
        mem_ack_i  = 1'b1;
        mem_data_i = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 64'h0;
        if (reads < 16 && mem_addr_o != exp_addr[reads]) addr_bad++;
        reads++;
        if (poke_arm && reads == poke_at) begin
          start_b  = 1'b1;
          poke_arm = 1'b0;
        end
      end else begin
        wait_cnt++;
      end
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic setup(input vec_t t);
    logic [31:0] g;
    logic [63:0] e;
    mem.delete();
    for (int p = 0; p < 2; p++) begin
      g = grp_of(t.vsid, t.ea, t.sdr, p[0]);
      for (int k = 0; k < 8; k++) begin
        exp_addr[p*8+k] = {g[31:6], k[2:0], 3'b000};
        if (t.where == 2 || p < int'(t.where) || (p == int'(t.where) && k < int'(t.slot))) begin
          case ((p*8 + k) % 4)
            0: e = mk_pte(1'b0, t.vsid, p[0], t.ea[27:22], 20'h11111, 4'h0, 2'h0);
            1: e = mk_pte(1'b1, t.vsid, ~p[0], t.ea[27:22], 20'h22222, 4'h0, 2'h0);
            2: e = mk_pte(1'b1, t.vsid, p[0], t.ea[27:22] ^ 6'h01, 20'h33333, 4'h0, 2'h0);
            default: e = mk_pte(1'b1, t.vsid ^ 24'h800000, p[0], t.ea[27:22], 20'h44444, 4'h0, 2'h0);
          endcase
          mem[exp_addr[p*8+k]] = e;
        end else if (p == int'(t.where) && k == int'(t.slot)) begin
          mem[exp_addr[p*8+k]] = mk_pte(1'b1, t.vsid, p[0], t.ea[27:22], t.rpn, t.wimg, t.pp);
        end else if (p == int'(t.where)) begin
          mem[exp_addr[p*8+k]] = mk_pte(1'b1, t.vsid, p[0], t.ea[27:22], ~t.rpn, ~t.wimg, ~t.pp);
        end
      end
    end
    lat       = int'(t.lat);
    reads     = 0;
    addr_bad  = 0;
    stall_bad = 0;
  endtask

  task automatic pulse_start(input logic [23:0] v, input logic [31:0] ea, input logic [31:0] sdr);
    vsid_i  = v;
    ea_i    = ea;
    sdr_i   = sdr;
    start_a = 1'b1;
    @(negedge clk_i);
    start_a = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      if (done_o) begin
        seen = 1'b1;
        break;
      end
    end
    if (!seen) chk(1'b0, "R6 done timeout", 0, 1);
  endtask

  task automatic judge(input vec_t t, input string tag);
    int  exp_reads;
    bit  exp_hit;
    exp_hit   = (t.where != 2);
    exp_reads = exp_hit ? int'(t.where) * 8 + int'(t.slot) + 1 : 16;
    chk(hit_o == exp_hit && fault_o == !exp_hit, exp_hit ? {tag, " R4 hit"} : {tag, " R6 fault"},
        {hit_o, fault_o}, {exp_hit, !exp_hit});
    if (exp_hit) begin
      chk(ra_o == {t.rpn, t.ea[11:0]}, {tag, " R5 ra"}, ra_o, {t.rpn, t.ea[11:0]});
      chk(wimg_o == t.wimg && pp_o == t.pp, {tag, " R5 wimg/pp"}, {wimg_o, pp_o}, {t.wimg, t.pp});
    end
    chk(reads == exp_reads, {tag, " R3 read count"}, reads, exp_reads);
    chk(addr_bad == 0, (t.where == 0) ? {tag, " R1 addresses"} : {tag, " R2 addresses"}, addr_bad, 0);
    if (t.lat != 0) chk(stall_bad == 0, {tag, " R9 stable address"}, stall_bad, 0);
  endtask

  initial begin
    bit seen;
    vec_t t;
    mem_ack_i  = 1'b0;
    mem_data_i = '0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !mem_req_o && !done_o, "R8 reset state", {busy_o, mem_req_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      setup(VECS[i]);
      pulse_start(VECS[i].vsid, VECS[i].ea, VECS[i].sdr);
      wait_done(seen);
      if (seen) begin
        judge(VECS[i], $sformatf("vec%0d", i));
        @(negedge clk_i);
        chk(!done_o, "R6 one-cycle done", done_o, 0);
      end
    end

    // R7: start mid-walk with other operands is dropped
    t = VECS[3];
    setup(t);
    pulse_start(t.vsid, t.ea, t.sdr);
    repeat (5) @(negedge clk_i);
    pulse_start(~t.vsid, ~t.ea, t.sdr);
    wait_done(seen);
    if (seen) judge(t, "R7 mid-walk start");

    // R7: start coinciding with the final acknowledge is dropped
    t = VECS[0];
    setup(t);
    poke_arm = 1'b1;
    poke_at  = 1;
    pulse_start(t.vsid, t.ea, t.sdr);
    ea_i = 32'hDEAD0000;
    wait_done(seen);
    if (seen) judge(t, "R7 start on last ack");
    repeat (6) @(negedge clk_i);
    chk(!busy_o && reads == 1, "R7 no walk after last-ack start", {busy_o, 8'(reads)}, 1);

    // R7: start in the done cycle is accepted
    t = VECS[1];
    setup(t);
    pulse_start(t.vsid, t.ea, t.sdr);
    wait_done(seen);
    if (seen) begin
      setup(VECS[2]);
      pulse_start(VECS[2].vsid, VECS[2].ea, VECS[2].sdr);
      chk(busy_o, "R7 start in done cycle accepted", busy_o, 1);
      wait_done(seen);
      if (seen) judge(VECS[2], "R7 back-to-back");
    end

    repeat (3) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule